// File: doc/BRIEF.md
# Cascadable Magnitude Comparator Chain

This block decides whether an unsigned operand A is greater than, less than or equal to an unsigned operand B. It is built from identical 4-bit digit slices wired in series. Each slice compares its own digit of A against the matching digit of B. It also takes a three-wire verdict (greater, less, equal) from the slice one digit below. It then produces its own three-wire verdict for the slice one digit above. The verdict travels upward from the least significant digit, and the most significant digit has the last word.

A slice whose digits differ produces its verdict from those digits alone. A slice whose digits match forwards the verdict it received. The top wrapper does three things. It splits the wide operands into digits, with slice k taking bits [4k+3:4k]. It seeds the lowest slice with the verdict "equal". It presents the final three flags. The whole structure is combinational. The number of slices and the choice of digit-compare circuit are parameters.

Top module: `mag_cmp_chain`

## Requirements
- R1: gt_o is 1 and the other two flags are 0 exactly when A > B as unsigned numbers.
- R2: lt_o is 1 and the other two flags are 0 exactly when A < B as unsigned numbers.
- R3: eq_o is 1 and the other two flags are 0 exactly when A == B. This follows from the lowest slice being seeded with greater=0, less=0, equal=1.
- R4: For every operand pair, exactly one of gt_o, lt_o, eq_o is 1.
- R5: A slice whose A digit differs from its B digit outputs greater (A digit larger) or less (A digit smaller) for all eight combinations of its cascade inputs.
- R6: A slice whose digits are equal copies a legal one-hot cascade input to its outputs: greater to greater, less to less, equal to equal.
- R7: A slice whose digits are equal outputs greater=0, less=0, equal=1 when its cascade inputs are not one-hot (none set, or two or more set).
- R8: When the most significant digits differ, the result follows that digit alone, even when every lower digit points the other way.
- R9: The operand width is 4 × NUM_SLICES (16 bits by default). Slice k compares bits [4k+3:4k]. A difference confined to any one digit position decides the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4*NUM_SLICES | Unsigned operand A |
| b_i | input | 4*NUM_SLICES | Unsigned operand B |
| gt_o | output | 1 | A is greater than B |
| lt_o | output | 1 | A is less than B |
| eq_o | output | 1 | A equals B |

## Verification
An exhaustive sweep covers every pair of low bytes while the upper digits are held equal. This separates correct forwarding through equal upper slices from a chain that lets the seed or an upper slice mask the low digits. Operands that differ in only one digit, at each position in turn, show whether every slice sits at its correct bit range. Operands whose top digit disagrees with all lower digits test that the top digit dominates. A standalone slice is driven with every cascade combination. This tells digit override apart from forwarding and from recovery on illegal inputs. Random full-width pairs cover the remaining space.

// File: rtl/cmp_pkg.sv
`timescale 1ns/1ps
package cmp_pkg;
   localparam int DIGIT_BITS = 4;

   typedef struct packed {
      logic gt;
      logic lt;
      logic eq;
   } verdict_t;

   localparam verdict_t SEED_VERDICT = '{gt: 1'b0, lt: 1'b0, eq: 1'b1};

   function automatic logic is_onehot3(input verdict_t v);
      return (v.gt & ~v.lt & ~v.eq) | (~v.gt & v.lt & ~v.eq) | (~v.gt & ~v.lt & v.eq);
   endfunction
endpackage

// File: rtl/mag_digit_cmp.sv
`timescale 1ns/1ps
module mag_digit_cmp #(
   parameter int W    = 4,
   parameter int IMPL = 0
) (
   input  logic [W-1:0] a_dig,
   input  logic [W-1:0] b_dig,
   output logic         a_gt,
   output logic         a_lt
);
   if (W < 1) begin : g_bad_w
      $error("mag_digit_cmp: W must be at least 1");
   end
   if (IMPL != 0 && IMPL != 1) begin : g_bad_impl
      $error("mag_digit_cmp: IMPL must be 0 or 1");
   end

   if (IMPL == 0) begin : g_rel
      assign a_gt = (a_dig > b_dig);
      assign a_lt = (a_dig < b_dig);
   end else begin : g_sub
      logic [W:0] diff;
      assign diff = {1'b0, a_dig} - {1'b0, b_dig};
      assign a_lt = diff[W];
      assign a_gt = ~diff[W] & (|diff[W-1:0]);
   end
endmodule

// File: rtl/mag_cmp_slice.sv
`timescale 1ns/1ps
module mag_cmp_slice
   import cmp_pkg::*;
#(
   parameter int W    = DIGIT_BITS,
   parameter int IMPL = 0
) (
   input  logic [W-1:0] a_dig,
   input  logic [W-1:0] b_dig,
   input  logic         casc_gt,
   input  logic         casc_lt,
   input  logic         casc_eq,
   output logic         out_gt,
   output logic         out_lt,
   output logic         out_eq
);
   logic     dig_gt, dig_lt;
   verdict_t below, result;

   mag_digit_cmp #(.W(W), .IMPL(IMPL)) u_dig (
      .a_dig (a_dig),
      .b_dig (b_dig),
      .a_gt  (dig_gt),
      .a_lt  (dig_lt)
   );

   assign below = '{gt: casc_gt, lt: casc_lt, eq: casc_eq};

   always_comb begin
      if (dig_gt)                 result = '{gt: 1'b1, lt: 1'b0, eq: 1'b0};
      else if (dig_lt)            result = '{gt: 1'b0, lt: 1'b1, eq: 1'b0};
      else if (is_onehot3(below)) result = below;
      else                        result = SEED_VERDICT;
   end

   assign out_gt = result.gt;
   assign out_lt = result.lt;
   assign out_eq = result.eq;
endmodule

// File: rtl/mag_cmp_chain.sv
`timescale 1ns/1ps
module mag_cmp_chain
   import cmp_pkg::*;
#(
   parameter  int NUM_SLICES = 4,
   parameter  int CMP_IMPL   = 0,
   localparam int OP_W       = NUM_SLICES * DIGIT_BITS
) (
   input  logic [OP_W-1:0] a_i,
   input  logic [OP_W-1:0] b_i,
   output logic            gt_o,
   output logic            lt_o,
   output logic            eq_o
);
   if (NUM_SLICES < 1) begin : g_bad_n
      $error("mag_cmp_chain: NUM_SLICES must be at least 1");
   end

   logic [NUM_SLICES:0] link_gt, link_lt, link_eq;

   assign link_gt[0] = SEED_VERDICT.gt;
   assign link_lt[0] = SEED_VERDICT.lt;
   assign link_eq[0] = SEED_VERDICT.eq;

   for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
      mag_cmp_slice #(.W(DIGIT_BITS), .IMPL(CMP_IMPL)) u_slice (
         .a_dig   (a_i[k*DIGIT_BITS +: DIGIT_BITS]),
         .b_dig   (b_i[k*DIGIT_BITS +: DIGIT_BITS]),
         .casc_gt (link_gt[k]),
         .casc_lt (link_lt[k]),
         .casc_eq (link_eq[k]),
         .out_gt  (link_gt[k+1]),
         .out_lt  (link_lt[k+1]),
         .out_eq  (link_eq[k+1])
      );
   end

   assign gt_o = link_gt[NUM_SLICES];
   assign lt_o = link_lt[NUM_SLICES];
   assign eq_o = link_eq[NUM_SLICES];
endmodule

// File: rtl/mag_cmp_chain_chk.sv
`timescale 1ns/1ps
module mag_cmp_chain_chk
   import cmp_pkg::*;
#(
   parameter  int NUM_SLICES = 4,
   localparam int OP_W       = NUM_SLICES * DIGIT_BITS
) (
   input logic [OP_W-1:0] a_i,
   input logic [OP_W-1:0] b_i,
   input logic            gt_o,
   input logic            lt_o,
   input logic            eq_o
);
   logic [DIGIT_BITS-1:0] a_top, b_top;
   assign a_top = a_i[OP_W-1 -: DIGIT_BITS];
   assign b_top = b_i[OP_W-1 -: DIGIT_BITS];

   always_comb begin
      // R4
      onehot_flags_chk: assert ($countones({gt_o, lt_o, eq_o}) == 1)
         else $error("flags not one-hot");
      // R1
      greater_ref_chk: assert (gt_o == (a_i > b_i))
         else $error("gt_o disagrees with A>B");
      // R2
      less_ref_chk: assert (lt_o == (a_i < b_i))
         else $error("lt_o disagrees with A<B");
      // R3
      equal_ref_chk: assert (eq_o == (a_i == b_i))
         else $error("eq_o disagrees with A==B");
      // R8
      top_digit_rules_chk: assert ((a_top == b_top) || (gt_o == (a_top > b_top)))
         else $error("top digit did not decide");
   end
endmodule

bind mag_cmp_chain mag_cmp_chain_chk #(.NUM_SLICES(NUM_SLICES)) u_chk (
   .a_i  (a_i),
   .b_i  (b_i),
   .gt_o (gt_o),
   .lt_o (lt_o),
   .eq_o (eq_o)
);

// File: tb/sim_mag_cmp_chain.sv
`timescale 1ns/1ps
module sim_mag_cmp_chain;
   localparam int N  = 4;
   localparam int OW = 4 * N;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [OW-1:0] a_r = '0, b_r = '0;
   logic gt, lt, eq;
   logic [3:0] s_a = '0, s_b = '0;
   logic s_cg = 1'b0, s_cl = 1'b0, s_ce = 1'b1;
   logic s_og, s_ol, s_oe;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   mag_cmp_chain #(.NUM_SLICES(N)) u0 (
      .a_i(a_r), .b_i(b_r), .gt_o(gt), .lt_o(lt), .eq_o(eq)
   );

   mag_cmp_slice u1 (
      .a_dig(s_a), .b_dig(s_b), .casc_gt(s_cg), .casc_lt(s_cl), .casc_eq(s_ce),
      .out_gt(s_og), .out_lt(s_ol), .out_eq(s_oe)
   );

   task automatic expect3(input string tag, input logic [2:0] act, input logic [2:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got {gt,lt,eq}=%b expected %b", tag, act, exp);
      end
   endtask

   task automatic chain_case(input string tag, input logic [OW-1:0] a, input logic [OW-1:0] b);
      logic [2:0] act;
      a_r = a; b_r = b;
      #1;
      act = {gt, lt, eq};
      expect3(tag, act, {a > b, a < b, a == b});
      n_chk++;
      if ($countones(act) != 1) begin
         n_fail++;
         $display("FAIL R4: flags %b not one-hot, expected one bit set", act);
      end
   endtask

   task automatic t_idle;
      // R3: zero operands after reset give equal
      chain_case("R3", '0, '0);
   endtask

   task automatic t_exhaustive_low_byte;
      logic [OW-9:0] hi;
      hi = OW'(16'hA500) >> 8;
      for (int x = 0; x < 256; x++) begin
         for (int y = 0; y < 256; y++) begin
            chain_case(x > y ? "R1" : (x < y ? "R2" : "R3"),
                       {hi, 8'(x)}, {hi, 8'(y)});
         end
      end
   endtask

   task automatic t_top_digit;
      // R8: top digit opposite to every lower digit
      chain_case("R8", {4'h9, {(OW-4){1'b0}}}, {4'h8, {(OW-4){1'b1}}});
      chain_case("R8", {4'h2, {(OW-4){1'b1}}}, {4'h3, {(OW-4){1'b0}}});
      chain_case("R8", {4'hF, {(OW-4){1'b0}}}, {4'h0, {(OW-4){1'b1}}});
   endtask

   task automatic t_single_digit;
      logic [OW-1:0] base, a, b;
      for (int k = 0; k < N; k++) begin
         base = OW'($urandom);
         a = base; b = base;
         a[k*4 +: 4] = 4'h9; b[k*4 +: 4] = 4'h6;
         chain_case("R9", a, b);
         chain_case("R9", b, a);
         if (k == 0) begin
            // R6: lowest-digit verdict forwarded through equal upper slices
            chain_case("R6", a, b);
         end
      end
   endtask

   task automatic t_random;
      logic [OW-1:0] a, b;
      for (int i = 0; i < 3000; i++) begin
         a = OW'($urandom); b = OW'($urandom);
         if (i % 3 == 0) b = a;
         chain_case(a > b ? "R1" : (a < b ? "R2" : "R3"), a, b);
      end
   endtask

   task automatic t_slice_override;
      for (int c = 0; c < 8; c++) begin
         {s_cg, s_cl, s_ce} = 3'(c);
         s_a = 4'hC; s_b = 4'h3; #1;
         expect3("R5", {s_og, s_ol, s_oe}, 3'b100);
         s_a = 4'h3; s_b = 4'hC; #1;
         expect3("R5", {s_og, s_ol, s_oe}, 3'b010);
      end
   endtask

   task automatic t_slice_forward;
      s_a = 4'h7; s_b = 4'h7;
      {s_cg, s_cl, s_ce} = 3'b100; #1; expect3("R6", {s_og, s_ol, s_oe}, 3'b100);
      {s_cg, s_cl, s_ce} = 3'b010; #1; expect3("R6", {s_og, s_ol, s_oe}, 3'b010);
      {s_cg, s_cl, s_ce} = 3'b001; #1; expect3("R6", {s_og, s_ol, s_oe}, 3'b001);
   endtask

   task automatic t_slice_illegal;
      logic [2:0] bad [5] = '{3'b000, 3'b110, 3'b101, 3'b011, 3'b111};
      s_a = 4'hA; s_b = 4'hA;
      foreach (bad[i]) begin
         {s_cg, s_cl, s_ce} = bad[i]; #1;
         expect3("R7", {s_og, s_ol, s_oe}, 3'b001);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_idle();
      t_exhaustive_low_byte();
      t_top_digit();
      t_single_digit();
      t_random();
      t_slice_override();
      t_slice_forward();
      t_slice_illegal();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule